// File: doc/BRIEF.md
# Disk Controller Timing Configuration Register File

This block holds the device-specific configuration registers of a disk controller: a timing word for each of the two channels, a device timing byte, an ultra-DMA control byte, an ultra-DMA timing word and a 16-bit controller configuration word. A configuration access presents an offset and a size of 1, 2 or 4 bytes. Each register accepts only certain combinations of size and offset. A byte write to either half of the configuration word changes only that half. Any combination that is not supported reads as zero, writes nothing and raises a one-cycle error pulse.

Write data and read data are right-justified. A byte access uses bits 7:0 and a 16-bit access uses bits 15:0, whatever the offset. The block also watches writes to the standard command register and keeps two enable outputs, I/O decode and bus mastering, in step with that register. The generic header below offset 0x40 is not decoded here, so an access there counts as unsupported.

Top module: `disk_timing_cfg`

## Requirements
- R1: After reset, both channel timing registers read 0x8000 (decode-enable, bit 15, set). Device timing, ultra-DMA control, ultra-DMA timing and configuration read 0. `ioEnable`, `busMasterEnable`, `accError` and `rdValid` are 0.
- R2: A 4-byte access (size code 2) is supported only at offsets 0x40 and 0x54. A read returns the 16-bit primary timing or configuration register, zero-extended. A write loads bits 15:0 of the data.
- R3: A 2-byte access (size code 1) is supported at 0x40, 0x42, 0x48, 0x4A and 0x54. The 8-bit ultra-DMA control register at 0x48 keeps bits 7:0 of a write and reads back zero-extended.
- R4: A byte read (size code 0) is supported at 0x41 and 0x43, which return bits 15:8 of the primary and secondary timing registers. It is also supported at 0x44, 0x48, 0x54 (configuration bits 7:0) and 0x55 (configuration bits 15:8).
- R5: A byte write is supported only at 0x44, 0x48, 0x54 and 0x55. A write to 0x54 or 0x55 replaces only configuration bits 7:0 or 15:8 respectively, with data bits 7:0.
- R6: Any other access is unsupported: size code 3, an offset not listed for that size, or a byte write to 0x41 or 0x43. A read then returns 0, a write changes no register, and `accError` is high for exactly the one cycle after the access.
- R7: In the cycle after `stdCmdWrite`, `ioEnable` equals bit 0 and `busMasterEnable` equals bit 2 of `stdCmdData`. Without `stdCmdWrite`, both outputs hold.
- R8: A read updates `rdData` and pulses `rdValid` for one cycle, in the cycle after the access. A write never pulses `rdValid`.

Size codes on `accSize`: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Configuration access this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accSize | input | 2 | Size code (0 byte, 1 half, 2 word, 3 reserved) |
| accOffset | input | 8 | Configuration-space byte offset |
| wrData | input | 32 | Right-justified write data |
| stdCmdWrite | input | 1 | Standard command register is being written |
| stdCmdData | input | 16 | Value written to the command register |
| rdData | output | 32 | Right-justified read data, registered |
| rdValid | output | 1 | One-cycle pulse marking new read data |
| accError | output | 1 | One-cycle pulse for an unsupported access |
| ioEnable | output | 1 | Captured I/O decode enable |
| busMasterEnable | output | 1 | Captured bus-master enable |

## Verification
A vector table sweeps every register at every size. It mixes supported and unsupported sizes at the same offset, for example a byte and a half read at 0x44, or a byte write and a byte read at 0x41. This separates a size check from a plain offset check. Each half of the configuration word is written separately and read back at byte, half and word size, which exposes lane merging into the wrong half and word reads that pick up a neighbour. An unsupported write is always followed by a read of the register it could have hit, so a dropped write guard is caught. Directed tests apply several command values that differ in bit 0 and bit 2, plus changes to the command data while the write strobe is low.

// File: rtl/dtcfg_pkg.sv
package dtcfg_pkg;
  localparam logic [7:0] OFF_PRI  = 8'h40;
  localparam logic [7:0] OFF_SEC  = 8'h42;
  localparam logic [7:0] OFF_DEV  = 8'h44;
  localparam logic [7:0] OFF_UCTL = 8'h48;
  localparam logic [7:0] OFF_UTIM = 8'h4A;
  localparam logic [7:0] OFF_CFG  = 8'h54;

  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3
  } accSize_e;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_PRI, SEL_PRI_HI, SEL_SEC, SEL_SEC_HI, SEL_DEV,
    SEL_UCTL, SEL_UTIM, SEL_CFG, SEL_CFG_LO, SEL_CFG_HI
  } rdSel_e;

  typedef struct packed {
    logic   wrPri;
    logic   wrSec;
    logic   wrDev;
    logic   wrUCtl;
    logic   wrUTim;
    logic   wrCfgLo;
    logic   wrCfgHi;
    logic   hiFromLane0;
    logic   rdStb;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/dtcfg_ctrl.sv
module dtcfg_ctrl
  import dtcfg_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [1:0]       accSize,
  input  logic [OFF_W-1:0] accOffset,
  output strobe_t          strb,
  output logic             rdValid,
  output logic             accError
);
  logic       legal;
  logic [7:0] off8;

  // Offsets above the 8-bit decode window never match a register.
  assign off8 = 8'(accOffset);

  always_comb begin
    strb  = '0;
    strb.rdSel = SEL_NONE;
    legal = 1'b0;
    if (accValid && (OFF_W <= 8 || (accOffset >> 8) == '0)) begin
      unique case (accSize_e'(accSize))
        SZ_BYTE: begin
          unique case (off8)
            OFF_DEV: begin
              legal = 1'b1;
              if (accWrite) strb.wrDev = 1'b1; else strb.rdSel = SEL_DEV;
            end
            OFF_UCTL: begin
              legal = 1'b1;
              if (accWrite) strb.wrUCtl = 1'b1; else strb.rdSel = SEL_UCTL;
            end
            OFF_PRI + 8'd1: begin
              legal = !accWrite;
              if (!accWrite) strb.rdSel = SEL_PRI_HI;
            end
            OFF_SEC + 8'd1: begin
              legal = !accWrite;
              if (!accWrite) strb.rdSel = SEL_SEC_HI;
            end
            OFF_CFG: begin
              legal = 1'b1;
              if (accWrite) strb.wrCfgLo = 1'b1; else strb.rdSel = SEL_CFG_LO;
            end
            OFF_CFG + 8'd1: begin
              legal = 1'b1;
              if (accWrite) begin
                strb.wrCfgHi     = 1'b1;
                strb.hiFromLane0 = 1'b1;
              end else strb.rdSel = SEL_CFG_HI;
            end
            default: legal = 1'b0;
          endcase
        end
        SZ_HALF: begin
          unique case (off8)
            OFF_PRI: begin
              legal = 1'b1;
              if (accWrite) strb.wrPri = 1'b1; else strb.rdSel = SEL_PRI;
            end
            OFF_SEC: begin
              legal = 1'b1;
              if (accWrite) strb.wrSec = 1'b1; else strb.rdSel = SEL_SEC;
            end
            OFF_UCTL: begin
              legal = 1'b1;
              if (accWrite) strb.wrUCtl = 1'b1; else strb.rdSel = SEL_UCTL;
            end
            OFF_UTIM: begin
              legal = 1'b1;
              if (accWrite) strb.wrUTim = 1'b1; else strb.rdSel = SEL_UTIM;
            end
            OFF_CFG: begin
              legal = 1'b1;
              if (accWrite) begin
                strb.wrCfgLo = 1'b1;
                strb.wrCfgHi = 1'b1;
              end else strb.rdSel = SEL_CFG;
            end
            default: legal = 1'b0;
          endcase
        end
        SZ_WORD: begin
          unique case (off8)
            OFF_PRI: begin
              legal = 1'b1;
              if (accWrite) strb.wrPri = 1'b1; else strb.rdSel = SEL_PRI;
            end
            OFF_CFG: begin
              legal = 1'b1;
              if (accWrite) begin
                strb.wrCfgLo = 1'b1;
                strb.wrCfgHi = 1'b1;
              end else strb.rdSel = SEL_CFG;
            end
            default: legal = 1'b0;
          endcase
        end
        default: legal = 1'b0;
      endcase
      strb.rdStb = !accWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      accError <= 1'b0;
    end else begin
      rdValid  <= accValid && !accWrite;
      accError <= accValid && !legal;
    end
  end

  // R6: the error pulse only ever follows an access
  assert_err_follows_access_R6: assert property (@(posedge clk) disable iff (!rstN)
    accError |-> $past(accValid));
  // R8: read valid only follows a read access
  assert_rdvalid_follows_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(accValid && !accWrite));
endmodule

// File: rtl/dtcfg_regs.sv
module dtcfg_regs
  import dtcfg_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          CMD_W      = 16,
  parameter int          IO_BIT     = 0,
  parameter int          BM_BIT     = 2,
  parameter logic [15:0] TIMING_RST = 16'h8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              stdCmdWrite,
  input  logic [CMD_W-1:0]  stdCmdData,
  output logic [DATA_W-1:0] rdData,
  output logic              ioEnable,
  output logic              busMasterEnable
);
  logic [HALF_W-1:0] priTiming, secTiming, uTiming;
  logic [BYTE_W-1:0] devTiming, uCtl, cfgLo, cfgHi;
  logic [DATA_W-1:0] rdMux;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priTiming <= TIMING_RST;
      secTiming <= TIMING_RST;
      uTiming   <= '0;
      devTiming <= '0;
      uCtl      <= '0;
      cfgLo     <= '0;
      cfgHi     <= '0;
    end else begin
      if (strb.wrPri)   priTiming <= wrData[HALF_W-1:0];
      if (strb.wrSec)   secTiming <= wrData[HALF_W-1:0];
      if (strb.wrUTim)  uTiming   <= wrData[HALF_W-1:0];
      if (strb.wrDev)   devTiming <= wrData[BYTE_W-1:0];
      if (strb.wrUCtl)  uCtl      <= wrData[BYTE_W-1:0];
      if (strb.wrCfgLo) cfgLo     <= wrData[BYTE_W-1:0];
      if (strb.wrCfgHi) cfgHi     <= strb.hiFromLane0 ? wrData[BYTE_W-1:0]
                                                     : wrData[HALF_W-1:BYTE_W];
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_PRI:    rdMux = DATA_W'(priTiming);
      SEL_PRI_HI: rdMux = DATA_W'(priTiming[HALF_W-1:BYTE_W]);
      SEL_SEC:    rdMux = DATA_W'(secTiming);
      SEL_SEC_HI: rdMux = DATA_W'(secTiming[HALF_W-1:BYTE_W]);
      SEL_DEV:    rdMux = DATA_W'(devTiming);
      SEL_UCTL:   rdMux = DATA_W'(uCtl);
      SEL_UTIM:   rdMux = DATA_W'(uTiming);
      SEL_CFG:    rdMux = DATA_W'({cfgHi, cfgLo});
      SEL_CFG_LO: rdMux = DATA_W'(cfgLo);
      SEL_CFG_HI: rdMux = DATA_W'(cfgHi);
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData          <= '0;
      ioEnable        <= 1'b0;
      busMasterEnable <= 1'b0;
    end else begin
      if (strb.rdStb) rdData <= rdMux;
      if (stdCmdWrite) begin
        ioEnable        <= stdCmdData[IO_BIT];
        busMasterEnable <= stdCmdData[BM_BIT];
      end
    end
  end

  // R6: a timing register moves only under its own write strobe
  assert_pri_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrPri |=> $stable(priTiming));
  // R5: a high-byte config write leaves the low byte alone
  assert_cfg_lo_keep_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCfgHi && !strb.wrCfgLo) |=> $stable(cfgLo));
  // R7: enables follow the command value one cycle later
  assert_cmd_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    stdCmdWrite |=> (ioEnable == $past(stdCmdData[IO_BIT]))
                 && (busMasterEnable == $past(stdCmdData[BM_BIT])));
  // R7: enables hold without a command write
  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !stdCmdWrite |=> $stable(ioEnable) && $stable(busMasterEnable));
endmodule

// File: rtl/disk_timing_cfg.sv
module disk_timing_cfg
  import dtcfg_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          OFF_W      = 8,
  parameter int          CMD_W      = 16,
  parameter int          IO_BIT     = 0,
  parameter int          BM_BIT     = 2,
  parameter logic [15:0] TIMING_RST = 16'h8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [1:0]        accSize,
  input  logic [OFF_W-1:0]  accOffset,
  input  logic [DATA_W-1:0] wrData,
  input  logic              stdCmdWrite,
  input  logic [CMD_W-1:0]  stdCmdData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              accError,
  output logic              ioEnable,
  output logic              busMasterEnable
);
  strobe_t strb;

  dtcfg_ctrl #(.OFF_W(OFF_W)) uCtrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accSize(accSize), .accOffset(accOffset), .strb(strb),
    .rdValid(rdValid), .accError(accError)
  );

  dtcfg_regs #(
    .DATA_W(DATA_W), .CMD_W(CMD_W), .IO_BIT(IO_BIT), .BM_BIT(BM_BIT),
    .TIMING_RST(TIMING_RST)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .stdCmdWrite(stdCmdWrite), .stdCmdData(stdCmdData), .rdData(rdData),
    .ioEnable(ioEnable), .busMasterEnable(busMasterEnable)
  );
endmodule

// File: tb/sim_disk_timing_cfg.sv
module sim_disk_timing_cfg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0, accWrite = 1'b0;
  logic [1:0]  accSize = '0;
  logic [7:0]  accOffset = '0;
  logic [31:0] wrData = '0;
  logic        stdCmdWrite = 1'b0;
  logic [15:0] stdCmdData = '0;
  logic [31:0] rdData;
  logic        rdValid, accError, ioEnable, busMasterEnable;
  int          nChecks = 0, nFails = 0;
  bit          done = 1'b0;

  always #10ns clk = ~clk;

  disk_timing_cfg u0 (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accSize(accSize), .accOffset(accOffset), .wrData(wrData),
    .stdCmdWrite(stdCmdWrite), .stdCmdData(stdCmdData), .rdData(rdData),
    .rdValid(rdValid), .accError(accError), .ioEnable(ioEnable),
    .busMasterEnable(busMasterEnable)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [7:0]  off;
    logic [31:0] data;
    logic        err;
    logic [31:0] rd;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t mk(logic wr, logic [1:0] sz, logic [7:0] off,
                              logic [31:0] data, logic err, logic [31:0] rd,
                              logic [3:0] req);
    return '{wr: wr, sz: sz, off: off, data: data, err: err, rd: rd, req: req};
  endfunction

  localparam int NV = 38;
  localparam vec_t VEC [NV] = '{
    mk(0, 2, 8'h40, 0, 0, 32'h8000, 1),        // R1 word read primary reset
    mk(0, 1, 8'h42, 0, 0, 32'h8000, 1),        // R1 secondary reset
    mk(0, 0, 8'h44, 0, 0, 32'h0, 1),           // R1 device timing reset
    mk(0, 1, 8'h4A, 0, 0, 32'h0, 1),           // R1 udma timing reset
    mk(0, 1, 8'h48, 0, 0, 32'h0, 1),           // R1 udma control reset
    mk(0, 1, 8'h54, 0, 0, 32'h0, 1),           // R1 config reset
    mk(0, 0, 8'h41, 0, 0, 32'h80, 4),          // R4 primary high byte
    mk(0, 0, 8'h40, 0, 1, 32'h0, 6),           // R6 byte read low timing
    mk(1, 1, 8'h42, 32'h1234, 0, 0, 3),        // R3 half write secondary
    mk(0, 0, 8'h43, 0, 0, 32'h12, 4),          // R4 secondary high byte
    mk(0, 1, 8'h42, 0, 0, 32'h1234, 3),        // R3
    mk(1, 2, 8'h40, 32'hDEAD5678, 0, 0, 2),    // R2 word write primary
    mk(0, 1, 8'h40, 0, 0, 32'h5678, 2),        // R2 low 16 kept
    mk(0, 2, 8'h40, 0, 0, 32'h5678, 2),        // R2 zero-extended
    mk(1, 1, 8'h54, 32'hA1B2, 0, 0, 3),        // R3 half write config
    mk(1, 0, 8'h55, 32'h3C, 0, 0, 5),          // R5 high byte only
    mk(0, 1, 8'h54, 0, 0, 32'h3CB2, 5),        // R5
    mk(1, 0, 8'h54, 32'h4D, 0, 0, 5),          // R5 low byte only
    mk(0, 2, 8'h54, 0, 0, 32'h3C4D, 5),        // R5 word read config
    mk(0, 0, 8'h55, 0, 0, 32'h3C, 4),          // R4 config high byte
    mk(0, 0, 8'h54, 0, 0, 32'h4D, 4),          // R4 config low byte
    mk(1, 0, 8'h44, 32'h77, 0, 0, 5),          // R5 device byte write
    mk(0, 0, 8'h44, 0, 0, 32'h77, 4),          // R4
    mk(0, 1, 8'h44, 0, 1, 32'h0, 6),           // R6 half at device timing
    mk(1, 1, 8'h48, 32'hABCD, 0, 0, 3),        // R3 udma control half
    mk(0, 1, 8'h48, 0, 0, 32'hCD, 3),          // R3 only 8 bits kept
    mk(1, 0, 8'h48, 32'h11, 0, 0, 5),          // R5
    mk(0, 0, 8'h48, 0, 0, 32'h11, 4),          // R4
    mk(1, 1, 8'h4A, 32'hFEDC, 0, 0, 3),        // R3 udma timing
    mk(0, 1, 8'h4A, 0, 0, 32'hFEDC, 3),        // R3
    mk(0, 0, 8'h4A, 0, 1, 32'h0, 6),           // R6 byte at udma timing
    mk(1, 0, 8'h41, 32'hFF, 1, 0, 6),          // R6 byte write high timing
    mk(0, 1, 8'h40, 0, 0, 32'h5678, 6),        // R6 unchanged
    mk(1, 2, 8'h42, 32'hFFFF, 1, 0, 6),        // R6 word at 0x42
    mk(0, 1, 8'h42, 0, 0, 32'h1234, 6),        // R6 unchanged
    mk(0, 3, 8'h40, 0, 1, 32'h0, 6),           // R6 reserved size
    mk(1, 1, 8'h10, 32'h5555, 1, 0, 6),        // R6 header offset
    mk(0, 2, 8'h48, 0, 1, 32'h0, 6)            // R6 word at 0x48
  };

  task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic access(vec_t v);
    @(negedge clk);
    accValid = 1'b1; accWrite = v.wr; accSize = v.sz;
    accOffset = v.off; wrData = v.data;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0; wrData = '0;
  endtask

  task automatic cmdWrite(logic [15:0] val, logic expIo, logic expBm);
    @(negedge clk);
    stdCmdWrite = 1'b1; stdCmdData = val;
    @(negedge clk);
    stdCmdWrite = 1'b0;
    check(ioEnable == expIo, "R7 ioEnable", 32'(ioEnable), 32'(expIo));
    check(busMasterEnable == expBm, "R7 busMasterEnable",
          32'(busMasterEnable), 32'(expBm));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 port reset state
    check(rdData == 0 && !rdValid && !accError, "R1 reset outputs",
          {rdData[29:0], rdValid, accError}, 32'h0);
    check(!ioEnable && !busMasterEnable, "R1 reset enables",
          32'({ioEnable, busMasterEnable}), 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i]);
      nChecks++;
      if (accError !== VEC[i].err || rdValid !== !VEC[i].wr ||
          (!VEC[i].wr && rdData !== VEC[i].rd)) begin
        nFails++;
        $display("FAIL R%0d vec %0d actual rd=%h err=%b vld=%b expected rd=%h err=%b vld=%b",
                 VEC[i].req, i, rdData, accError, rdValid, VEC[i].rd,
                 VEC[i].err, !VEC[i].wr);
      end
    end

    // R6 error pulse lasts one cycle
    access(mk(0, 1, 8'h44, 0, 1, 0, 6));
    @(negedge clk);
    check(!accError, "R6 error pulse width", 32'(accError), 32'h0);
    // R8 read data holds, no valid without an access
    check(!rdValid && rdData == 0, "R8 hold after idle",
          rdData, 32'h0);

    // R7 command captures
    cmdWrite(16'h0005, 1'b1, 1'b1);
    cmdWrite(16'h0004, 1'b0, 1'b1);
    cmdWrite(16'hFFFA, 1'b0, 1'b0);
    cmdWrite(16'h0001, 1'b1, 1'b0);
    @(negedge clk);
    stdCmdData = 16'h0004;
    repeat (2) @(negedge clk);
    check(ioEnable && !busMasterEnable, "R7 hold without write",
          32'({ioEnable, busMasterEnable}), 32'h2);
    access(mk(1, 1, 8'h40, 32'h0004, 0, 0, 7));
    check(ioEnable && !busMasterEnable, "R7 config write no effect",
          32'({ioEnable, busMasterEnable}), 32'h2);

    // R1 reset mid-run restores defaults
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    access(mk(0, 1, 8'h40, 0, 0, 32'h8000, 1));
    check(rdData == 32'h8000, "R1 reapplied reset", rdData, 32'h8000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule